// File: doc/BRIEF.md
# Bus Master DMA Status Registers

This block holds the software-visible state of a bus master disk DMA engine. It has two registers: a 32-bit descriptor table pointer and a status byte. The status byte carries three flags. The first records that the attached drive has raised its interrupt line. The second records that a bus transfer ended in a target or master abort. The third shows that a DMA command is running.

The engine that fetches descriptors and moves data sits outside this block. It reports to the block with two single-cycle pulses: one for an aborted transfer, and one for the completion of the region marked as the last in the table. Software reaches both registers through a simple strobe port. Each register is selected by a byte offset, and read data comes back on the clock after the read strobe. The command register's start bit arrives as a level input. Its rising edge starts a command and its falling edge stops one.

Top module: `bmd_status_regs`

## Requirements
- R1: A write to offset 0x04 stores write data bits 31:2 in the pointer. A read of offset 0x04 returns the stored bits 31:2 with bits 1:0 as 0, and `table_ptr` shows the same value on the clock after the write. The pointer has no reset value.
- R2: The interrupt flag (status bit 2) is set on the clock where `dev_irq` is seen high after having been low on the previous clock. A line that stays high or stays low sets nothing.
- R3: Writing 1 to status bit 2 clears the interrupt flag. If the line is still high at that point, the flag stays 0 until the line goes low and then high again.
- R4: The error flag (status bit 1) is set on every clock where `xfer_abort` is high, and writing 1 to status bit 1 clears it.
- R5: Writing 0 to bit 1 or bit 2 changes nothing. Writes to the active bit (bit 0) and to status bits 7:3 are ignored. Reads of offset 0x02 return 0 in bits 31:3.
- R6: When a set event and a write-1-to-clear reach the same flag on the same clock, the flag ends up set.
- R7: The active flag (status bit 0, also driven on `dma_active`) is set on the clock after `cmd_start` rises, and it is cleared on the clock after `cmd_start` falls.
- R8: `eot_last` clears the active flag. It has no effect when the flag is already clear. When a rising `cmd_start` coincides with `eot_last`, the flag is set.
- R9: While `rst_n` is low, the status flags and `reg_rdata` go to 0 and the two edge samplers track their lines. As a result, an interrupt line or start bit that is already high when reset is released does not count as an edge.
- R10: `reg_rdata` shows the addressed register on the clock after `reg_rd`. It reads 0 on any other clock, and it reads 0 for offsets other than 0x02 and 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data (status uses bits 7:0) |
| reg_rdata | output | 32 | Read data, one clock after `reg_rd` |
| dev_irq | input | 1 | Interrupt line from the drive |
| cmd_start | input | 1 | Start bit of the command register (level) |
| xfer_abort | input | 1 | Pulse: target or master abort on a transfer |
| eot_last | input | 1 | Pulse: last transfer of the final region completed |
| table_ptr | output | 32 | Current descriptor table pointer |
| dma_active | output | 1 | Active flag |

## Verification
Directed sequences cover several cases. Interrupt edges are tried against a line held high through a clear, which separates edge capture from level capture. Write-1 and write-0 patterns, including writes to the active and reserved bits, separate real clears from ignored writes. Collisions of a set event with a clear show which side wins. Start edges combined with end-of-transfer pulses, both with and without an active command, separate the priorities of the active flag. A long seeded random run then mixes line toggles, abort and end-of-transfer pulses, and reads and writes at mapped and unmapped offsets, so that orderings the directed cases do not reach are also compared against the bench's own model.

// File: rtl/bmd_pkg.sv
// Package: shared constants for the DMA status register block.
// Assumes byte offsets select whole registers; status lives in data bits 7:0.
package bmd_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int STAT_W   = 8;
    localparam int PTR_LSB  = 2;
    localparam int PTR_HI_W = REG_W - PTR_LSB;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h02;
    localparam logic [ADDR_W-1:0] OFF_PTR  = 8'h04;
    localparam int ST_ACT = 0;
    localparam int ST_ERR = 1;
    localparam int ST_IRQ = 2;
endpackage

// File: rtl/bmd_w1c_flag.sv
// Module: one sticky status flag with write-1-to-clear.
// EDGE_SET=1 sets on a low-to-high step of src; EDGE_SET=0 sets while src is high.
// The edge sampler follows src during reset, so a level held through reset is no edge.
// A set and a clear on the same clock leave the flag set.
module bmd_w1c_flag #(
    parameter bit EDGE_SET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic clr,
    output logic flag
);
    logic set_ev;

    generate
        if (EDGE_SET) begin : g_edge
            logic src_q;
            // Sample the source line every clock, reset included.
            always_ff @(posedge clk) begin
                src_q <= src;
            end
            assign set_ev = src & ~src_q;
        end else begin : g_level
            assign set_ev = src;
        end
    endgenerate

    // Hold the flag: set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/bmd_active_ctl.sv
// Module: active flag of a DMA command.
// A rising start bit sets the flag. A falling start bit or the last-region pulse clears it.
// A rise beats a coincident last-region pulse. The start sampler follows the line during reset.
module bmd_active_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic eot,
    output logic active
);
    logic start_q;
    logic start_rise;
    logic start_fall;

    // Remember the previous start level, also during reset.
    always_ff @(posedge clk) begin
        start_q <= start;
    end

    assign start_rise = start & ~start_q;
    assign start_fall = ~start & start_q;

    // Update the active flag from start edges and end of transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (start_rise) begin
            active <= 1'b1;
        end else if (start_fall || eot) begin
            active <= 1'b0;
        end
    end
endmodule

// File: rtl/bmd_ptr_reg.sv
// Module: descriptor table pointer storage.
// Only the dword address bits are stored. The register has no reset, so its value is
// undefined until the first write.
module bmd_ptr_reg
    import bmd_pkg::*;
(
    input  logic                clk,
    input  logic                wr_en,
    input  logic [PTR_HI_W-1:0] wdata_hi,
    output logic [REG_W-1:0]    ptr
);
    logic [PTR_HI_W-1:0] addr_q;

    // Load the upper address bits on a pointer write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr_q <= wdata_hi;
        end
    end

    assign ptr = {addr_q, {PTR_LSB{1'b0}}};
endmodule

// File: rtl/bmd_rd_port.sv
// Module: registered read-data path.
// Selects the register by byte offset and returns it one clock after the strobe.
// Unmapped offsets and idle clocks return 0.
module bmd_rd_port
    import bmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STAT_W-1:0] status,
    input  logic [REG_W-1:0]  ptr,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0] sel_data;

    // Choose the addressed register.
    always_comb begin
        case (addr)
            OFF_STAT: sel_data = {{(REG_W-STAT_W){1'b0}}, status};
            OFF_PTR:  sel_data = ptr;
            default:  sel_data = '0;
        endcase
    end

    // Register the read result; zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= sel_data;
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/bmd_status_regs.sv
// Module: top of the bus master DMA status register block.
// Decodes register writes, holds the interrupt, error and active flags and the
// descriptor table pointer, and returns read data one clock after a read strobe.
// Assumes a single register access per clock and pulse-wide abort/end events.
module bmd_status_regs
    import bmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              dev_irq,
    input  logic              cmd_start,
    input  logic              xfer_abort,
    input  logic              eot_last,
    output logic [REG_W-1:0]  table_ptr,
    output logic              dma_active
);
    logic              wr_stat;
    logic              wr_ptr;
    logic              st_irq;
    logic              st_err;
    logic [STAT_W-1:0] status;

    assign wr_stat = reg_wr && (reg_addr == OFF_STAT);
    assign wr_ptr  = reg_wr && (reg_addr == OFF_PTR);

    bmd_w1c_flag #(.EDGE_SET(1'b1)) u_irq_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (dev_irq),
        .clr  (wr_stat && reg_wdata[ST_IRQ]),
        .flag (st_irq)
    );

    bmd_w1c_flag #(.EDGE_SET(1'b0)) u_err_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (xfer_abort),
        .clr  (wr_stat && reg_wdata[ST_ERR]),
        .flag (st_err)
    );

    bmd_active_ctl u_active (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd_start),
        .eot   (eot_last),
        .active(dma_active)
    );

    bmd_ptr_reg u_ptr (
        .clk     (clk),
        .wr_en   (wr_ptr),
        .wdata_hi(reg_wdata[REG_W-1:PTR_LSB]),
        .ptr     (table_ptr)
    );

    // Assemble the status byte; the reserved bits are tied to 0.
    always_comb begin
        status         = '0;
        status[ST_ACT] = dma_active;
        status[ST_ERR] = st_err;
        status[ST_IRQ] = st_irq;
    end

    bmd_rd_port u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (reg_rd),
        .addr  (reg_addr),
        .status(status),
        .ptr   (table_ptr),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/bmd_status_chk.sv
// Module: property checker for bmd_status_regs, attached by bind.
// Observes ports and the two sticky flags; holds no state of its own.
module bmd_status_chk
    import bmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              dev_irq,
    input logic              cmd_start,
    input logic              xfer_abort,
    input logic              eot_last,
    input logic [REG_W-1:0]  table_ptr,
    input logic              dma_active,
    input logic              irq_flag,
    input logic              err_flag
);
    p_ptr_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_PTR) |=>
        (table_ptr[REG_W-1:PTR_LSB] == $past(reg_wdata[REG_W-1:PTR_LSB])
         && table_ptr[PTR_LSB-1:0] == '0));

    p_irq_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(dev_irq) && !$past(dev_irq, 2)));

    p_irq_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_STAT && reg_wdata[ST_IRQ]
         && !(dev_irq && !$past(dev_irq))) |=> !irq_flag);

    p_err_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(xfer_abort));

    p_stat_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_STAT) |=> (reg_rdata[REG_W-1:ST_IRQ+1] == '0));

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_STAT && reg_wdata[ST_ERR] && xfer_abort) |=> err_flag);

    p_start_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_start) |=> dma_active);

    p_start_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_start) |=> !dma_active);

    p_eot_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_last && !$rose(cmd_start)) |=> !dma_active);

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));
endmodule

bind bmd_status_regs bmd_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dev_irq   (dev_irq),
    .cmd_start (cmd_start),
    .xfer_abort(xfer_abort),
    .eot_last  (eot_last),
    .table_ptr (table_ptr),
    .dma_active(dma_active),
    .irq_flag  (st_irq),
    .err_flag  (st_err)
);

// File: tb/bmd_status_regs_bench.sv
// Bench: directed corner cases plus seeded random traffic, checked against a model.
module bmd_status_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_irq = 1'b0, cmd_start = 1'b0, xfer_abort = 1'b0, eot_last = 1'b0;
    logic [31:0] table_ptr;
    logic        dma_active;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmd_status_regs u_bmd_status_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_irq(dev_irq), .cmd_start(cmd_start), .xfer_abort(xfer_abort),
        .eot_last(eot_last), .table_ptr(table_ptr), .dma_active(dma_active)
    );

    // Stimulus for the next clock, applied by step().
    bit g_rst = 1'b0, g_wr = 1'b0, g_rd = 1'b0, g_irq = 1'b0, g_st = 1'b0;
    bit g_ab = 1'b0, g_eo = 1'b0;
    logic [7:0]  g_addr = '0;
    logic [31:0] g_wd = '0;

    // Reference model.
    bit m_irq = 0, m_err = 0, m_act = 0, m_irq_q = 0, m_st_q = 0;
    bit ptr_known = 0, rd_skip = 0, armed = 0;
    logic [31:0] m_ptr = '0;
    logic [31:0] exp_rdata = '0;
    string tag = "R9";

    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h02:   return {29'd0, m_irq, m_err, m_act};
            8'h04:   return m_ptr;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check_outputs();
        if (!armed) return;
        if (!rd_skip) begin
            n_cmp++;
            if (reg_rdata !== exp_rdata) begin
                n_bad++;
                $display("FAIL %s reg_rdata act=%h exp=%h", tag, reg_rdata, exp_rdata);
            end
        end
        n_cmp++;
        if (dma_active !== m_act) begin
            n_bad++;
            $display("FAIL %s dma_active act=%b exp=%b", tag, dma_active, m_act);
        end
        if (ptr_known) begin
            n_cmp++;
            if (table_ptr !== m_ptr) begin
                n_bad++;
                $display("FAIL %s table_ptr act=%h exp=%h", tag, table_ptr, m_ptr);
            end
        end
    endtask

    // One clock: check last results, drive new inputs, advance the model.
    task automatic step(input string t);
        bit rise_irq, rise_st, fall_st, clr_irq, clr_err;
        @(negedge clk);
        check_outputs();
        armed = 1;
        rst_n = g_rst; reg_wr = g_wr; reg_rd = g_rd; reg_addr = g_addr; reg_wdata = g_wd;
        dev_irq = g_irq; cmd_start = g_st; xfer_abort = g_ab; eot_last = g_eo;
        tag = t;
        rd_skip = g_rd && (g_addr == 8'h04) && !ptr_known;
        if (!g_rst) begin
            exp_rdata = '0; m_irq = 0; m_err = 0; m_act = 0;
        end else begin
            exp_rdata = g_rd ? model_read(g_addr) : 32'd0;
            rise_irq = g_irq && !m_irq_q;
            rise_st  = g_st && !m_st_q;
            fall_st  = !g_st && m_st_q;
            clr_irq  = g_wr && g_addr == 8'h02 && g_wd[2];
            clr_err  = g_wr && g_addr == 8'h02 && g_wd[1];
            m_irq = rise_irq ? 1'b1 : (clr_irq ? 1'b0 : m_irq);
            m_err = g_ab ? 1'b1 : (clr_err ? 1'b0 : m_err);
            m_act = rise_st ? 1'b1 : ((fall_st || g_eo) ? 1'b0 : m_act);
            if (g_wr && g_addr == 8'h04) begin
                m_ptr = {g_wd[31:2], 2'b00};
                ptr_known = 1;
            end
        end
        m_irq_q = g_irq;
        m_st_q  = g_st;
        g_wr = 0; g_rd = 0; g_ab = 0; g_eo = 0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input string t);
        g_rd = 1; g_addr = a; step(t);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string t);
        g_wr = 1; g_addr = a; g_wd = d; step(t);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0bd7));
        // R9: lines high through reset are not edges once it is released.
        g_rst = 0; g_irq = 1; g_st = 1;
        repeat (3) step("R9 reset");
        g_rst = 1; step("R9 release");
        rd_reg(8'h02, "R9 status after reset");
        step("R9 status after reset");
        g_st = 0; step("R9 start drop");
        step("R9 idle");

        // R2: a real low-to-high edge sets the interrupt flag.
        g_irq = 0; step("R2 line low");
        g_irq = 1; step("R2 line rise");
        rd_reg(8'h02, "R2 read irq");
        step("R2 read irq");
        // R3: clearing while the line is high keeps the flag clear.
        wr_reg(8'h02, 32'h4, "R3 clear irq");
        repeat (3) rd_reg(8'h02, "R3 stays clear");
        step("R3 stays clear");
        g_irq = 0; step("R3 line low");
        g_irq = 1; step("R3 new edge");
        rd_reg(8'h02, "R3 new edge");
        step("R3 new edge");

        // R5: zeros and writes to active/reserved bits change nothing.
        wr_reg(8'h02, 32'h0, "R5 write zero");
        wr_reg(8'h02, 32'hFFFF_FFF9, "R5 write act and reserved");
        rd_reg(8'h02, "R5 status unchanged");
        step("R5 status unchanged");

        // R4: abort sets error; write 1 clears it.
        g_ab = 1; step("R4 abort");
        rd_reg(8'h02, "R4 error set");
        wr_reg(8'h02, 32'h2, "R4 clear error");
        rd_reg(8'h02, "R4 error clear");
        step("R4 error clear");

        // R6: set and clear together leave both flags set.
        g_irq = 0; step("R6 line low");
        g_irq = 1; g_ab = 1; g_wr = 1; g_addr = 8'h02; g_wd = 32'h6; step("R6 collide");
        rd_reg(8'h02, "R6 both kept");
        step("R6 both kept");
        wr_reg(8'h02, 32'h6, "R6 cleanup");

        // R1: pointer keeps bits 31:2 only.
        wr_reg(8'h04, 32'hDEAD_BEEF, "R1 write ptr");
        rd_reg(8'h04, "R1 read ptr");
        step("R1 read ptr");
        wr_reg(8'h04, 32'h0001_0002, "R1 second ptr");
        rd_reg(8'h04, "R1 read ptr 2");
        step("R1 read ptr 2");

        // R7: start edges.
        g_st = 1; step("R7 start rise");
        rd_reg(8'h02, "R7 active set");
        g_st = 0; step("R7 start fall");
        step("R7 active clear");

        // R8: end of transfer and its priority.
        g_st = 1; step("R8 start");
        g_eo = 1; step("R8 eot clears");
        step("R8 inactive");
        g_eo = 1; step("R8 eot when idle");
        g_st = 0; step("R8 start low");
        g_st = 1; g_eo = 1; step("R8 rise beats eot");
        step("R8 active held");
        g_st = 0; step("R8 stop");

        // R10: unmapped offsets and idle cycles read 0.
        rd_reg(8'h08, "R10 unmapped");
        rd_reg(8'h00, "R10 offset zero");
        step("R10 no read");
        step("R10 idle");

        // Random traffic over all inputs.
        for (int i = 0; i < RAND_CYCLES; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 20) g_irq = ~g_irq;
            if ($urandom_range(0, 99) < 6) g_st = ~g_st;
            g_ab = ($urandom_range(0, 99) < 5);
            g_eo = ($urandom_range(0, 99) < 5);
            r = int'($urandom_range(0, 7));
            g_addr = (r < 3) ? 8'h02 : (r < 6) ? 8'h04 : 8'($urandom_range(0, 255));
            g_wd = $urandom();
            g_wr = ($urandom_range(0, 7) == 0);
            g_rd = !g_wr && ($urandom_range(0, 2) == 0);
            step("R2 R3 R4 R6 R7 R8 R10 random");
        end
        step("final");
        summary();
        $finish;
    end
endmodule